// File: doc/BRIEF.md
# Debug Event Status and Interrupt Gate

This block sits between the debug event detectors and the core's exception logic. Each cycle it takes a vector of single-cycle event pulses and a per-event enable vector. For each event that is allowed through, it sets a sticky bit in a status vector. It then decides, from the current status and the mode inputs, whether a debug interrupt is requested from the core or a halt is signalled to an external debugger.

Ownership of each event is fixed by a configuration vector. A hardware-owned event belongs to the external debugger, but only while external debug mode is on. Otherwise every event counts as software-owned.

The interrupt request is a level. It is computed from the stored status, so an event recorded while the machine-state debug enable was low still produces an interrupt later, as soon as that enable rises. A separate sticky flag marks that such a deferred (imprecise) event occurred. Software clears status bits and the deferred flag with write-one-to-clear strobes.

Top module: `dbg_evt_gate`

## Requirements
- R1: When `evt_pulse[i]`, `evt_en[i]` and at least one of `int_mode` or `ext_mode` are all 1 at a rising clock edge, `status[i]` reads 1 after that edge.
- R2: An event whose enable bit is 0, or an event that occurs while both `int_mode` and `ext_mode` are 0, leaves `status[i]` unchanged.
- R3: Status bits are sticky. `status[i]` clears only at an edge where `clr_wr` is 1 and `clr_mask[i]` is 1. A recording event on the same bit in the same cycle wins over the clear.
- R4: Event `i` is software-owned when `own_hw[i]` is 0 or `ext_mode` is 0. `irq` is 1 exactly when `int_mode` is 1, `dbg_en` is 1 and at least one software-owned bit of `status` is 1. It follows `status` and the mode inputs without any added register.
- R5: A software-owned event recorded while `dbg_en` is 0 causes no interrupt at first. `irq` then rises in the same cycle that `dbg_en` becomes 1, provided `int_mode` is 1.
- R6: While `ext_mode` is 1, a status bit with `own_hw[i]` = 1 never causes `irq`. `halt_req` is 1 exactly when `ext_mode` is 1 and some bit with `own_hw[i]` = 1 is set in `status`.
- R7: While `int_mode` is 0, `irq` is 0 whatever the status.
- R8: `imprecise` is set by any recording event at an edge where `dbg_en` is 0. It clears only at an edge where `clr_imprecise` is 1 and no such event occurs.
- R9: While `rst_n` is low, `status`, `imprecise`, `irq` and `halt_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_pulse | input | N_EVT | Raw debug event pulses, one bit per event |
| evt_en | input | N_EVT | Per-event enable |
| own_hw | input | N_EVT | 1 marks the event as hardware-owned |
| int_mode | input | 1 | Internal debug mode |
| ext_mode | input | 1 | External debug mode |
| dbg_en | input | 1 | Machine-state debug interrupt enable |
| clr_wr | input | 1 | Write-one-to-clear strobe for status |
| clr_mask | input | N_EVT | Status bits to clear when `clr_wr` is 1 |
| clr_imprecise | input | 1 | Clear strobe for the deferred-event flag |
| status | output | N_EVT | Sticky debug status bits |
| imprecise | output | 1 | Sticky flag: an event was recorded while `dbg_en` was 0 |
| irq | output | 1 | Level debug interrupt request to the core |
| halt_req | output | 1 | Halt indication to the external debugger |

## Verification
The assertions check on every cycle that status bits stay set without a clear, and that nothing is recorded while both modes are off. They also check that a deferred event raises the imprecise flag, and that `irq` stays low with either mode gate closed or with only hardware-owned bits pending in external mode. The exact truth of `irq` and `halt_req` over every combination of modes, ownership and enable comes from the bench's sweep. So do the deferred interrupt appearing when `dbg_en` later rises, the priority of set over clear, and the reset values.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;

  // An event is routed to the core unless the external debugger owns it.
  function automatic logic sw_owned(input logic hw_flag, input logic ext_on);
    return ~(hw_flag & ext_on);
  endfunction

endpackage

// File: rtl/dbg_evt_rst_sync.sv
module dbg_evt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/dbg_evt_status.sv
module dbg_evt_status #(
  parameter int unsigned N_EVT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_pulse,
  input  logic [N_EVT-1:0] evt_en,
  input  logic             int_mode,
  input  logic             ext_mode,
  input  logic             dbg_en,
  input  logic             clr_wr,
  input  logic [N_EVT-1:0] clr_mask,
  input  logic             clr_imprecise,
  output logic [N_EVT-1:0] status,
  output logic             imprecise
);

  logic             mode_on;
  logic [N_EVT-1:0] rec;
  logic [N_EVT-1:0] st_d;
  logic [N_EVT-1:0] st_q;
  logic             st_ce;
  logic             imp_d;
  logic             imp_q;
  logic             imp_ce;
  logic             any_rec;

  assign mode_on = int_mode | ext_mode;

  for (genvar i = 0; i < N_EVT; i++) begin : g_bit
    always_comb begin
      rec[i]  = evt_pulse[i] & evt_en[i] & mode_on;
      st_d[i] = rec[i] | (st_q[i] & ~(clr_wr & clr_mask[i]));
    end
  end

  always_comb begin
    any_rec = |rec;
    st_ce   = any_rec | clr_wr;
    imp_d   = (any_rec & ~dbg_en) | (imp_q & ~clr_imprecise);
    imp_ce  = any_rec | clr_imprecise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_ce) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      imp_q <= 1'b0;
    else if (imp_ce) imp_q <= imp_d;
  end

  assign status    = st_q;
  assign imprecise = imp_q;

endmodule

// File: rtl/dbg_evt_route.sv
module dbg_evt_route
  import dbg_evt_pkg::*;
#(
  parameter int unsigned N_EVT = 4
) (
  input  logic [N_EVT-1:0] status,
  input  logic [N_EVT-1:0] own_hw,
  input  logic             int_mode,
  input  logic             ext_mode,
  input  logic             dbg_en,
  output logic             irq,
  output logic             halt_req
);

  logic [N_EVT-1:0] sw_mask;
  logic [N_EVT-1:0] hw_mask;

  for (genvar i = 0; i < N_EVT; i++) begin : g_own
    assign sw_mask[i] = sw_owned(own_hw[i], ext_mode);
    assign hw_mask[i] = own_hw[i] & ext_mode;
  end

  always_comb begin
    irq      = int_mode & dbg_en & (|(status & sw_mask));
    halt_req = |(status & hw_mask);
  end

endmodule

// File: rtl/dbg_evt_gate.sv
module dbg_evt_gate #(
  parameter int unsigned N_EVT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_pulse,
  input  logic [N_EVT-1:0] evt_en,
  input  logic [N_EVT-1:0] own_hw,
  input  logic             int_mode,
  input  logic             ext_mode,
  input  logic             dbg_en,
  input  logic             clr_wr,
  input  logic [N_EVT-1:0] clr_mask,
  input  logic             clr_imprecise,
  output logic [N_EVT-1:0] status,
  output logic             imprecise,
  output logic             irq,
  output logic             halt_req
);

  logic rst_core_n;

  dbg_evt_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_core_n)
  );

  dbg_evt_status #(.N_EVT(N_EVT)) u_status (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .evt_pulse    (evt_pulse),
    .evt_en       (evt_en),
    .int_mode     (int_mode),
    .ext_mode     (ext_mode),
    .dbg_en       (dbg_en),
    .clr_wr       (clr_wr),
    .clr_mask     (clr_mask),
    .clr_imprecise(clr_imprecise),
    .status       (status),
    .imprecise    (imprecise)
  );

  dbg_evt_route #(.N_EVT(N_EVT)) u_route (
    .status  (status),
    .own_hw  (own_hw),
    .int_mode(int_mode),
    .ext_mode(ext_mode),
    .dbg_en  (dbg_en),
    .irq     (irq),
    .halt_req(halt_req)
  );

endmodule

// File: rtl/dbg_evt_gate_chk.sv
module dbg_evt_gate_chk #(
  parameter int unsigned N_EVT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_EVT-1:0] evt_pulse,
  input logic [N_EVT-1:0] evt_en,
  input logic [N_EVT-1:0] own_hw,
  input logic             int_mode,
  input logic             ext_mode,
  input logic             dbg_en,
  input logic             clr_wr,
  input logic [N_EVT-1:0] clr_mask,
  input logic [N_EVT-1:0] status,
  input logic             imprecise,
  input logic             irq
);

  for (genvar i = 0; i < N_EVT; i++) begin : g_chk
    // R3: a set bit survives every edge without a matching clear
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i] && !(clr_wr && clr_mask[i])) |=> status[i]);
    // R2: with both modes off a clear bit stays clear
    p_no_record_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_mode && !ext_mode && !status[i]) |=> !status[i]);
  end

  // R8: a recording event while the enable is low raises the flag
  p_deferred_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (((evt_pulse & evt_en) != '0) && (int_mode || ext_mode) && !dbg_en) |=> imprecise);

  // R7: internal mode off keeps the core request low
  p_int_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !int_mode |-> !irq);

  // R5: enable low keeps the core request low
  p_en_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_en |-> !irq);

  // R6: only hardware-owned bits pending in external mode never reach the core
  p_hw_noirq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && ((status & ~own_hw) == '0)) |-> !irq);

endmodule

bind dbg_evt_gate dbg_evt_gate_chk #(.N_EVT(N_EVT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .evt_pulse(evt_pulse),
  .evt_en   (evt_en),
  .own_hw   (own_hw),
  .int_mode (int_mode),
  .ext_mode (ext_mode),
  .dbg_en   (dbg_en),
  .clr_wr   (clr_wr),
  .clr_mask (clr_mask),
  .status   (status),
  .imprecise(imprecise),
  .irq      (irq)
);

// File: tb/dbg_evt_gate_bench.sv
`timescale 1ns/1ps
module dbg_evt_gate_bench;

  localparam int N = 4;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] evt_pulse;
  logic [N-1:0] evt_en;
  logic [N-1:0] own_hw;
  logic         int_mode;
  logic         ext_mode;
  logic         dbg_en;
  logic         clr_wr;
  logic [N-1:0] clr_mask;
  logic         clr_imprecise;
  logic [N-1:0] status;
  logic         imprecise;
  logic         irq;
  logic         halt_req;

  int checks = 0;
  int errors = 0;

  dbg_evt_gate #(.N_EVT(N)) u_dbg_evt_gate (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .evt_en(evt_en),
    .own_hw(own_hw), .int_mode(int_mode), .ext_mode(ext_mode), .dbg_en(dbg_en),
    .clr_wr(clr_wr), .clr_mask(clr_mask), .clr_imprecise(clr_imprecise),
    .status(status), .imprecise(imprecise), .irq(irq), .halt_req(halt_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic quiet();
    evt_pulse = '0; clr_wr = 1'b0; clr_mask = '0; clr_imprecise = 1'b0;
  endtask

  // one cycle of clearing everything, ends on a falling edge
  task automatic clear_all();
    @(negedge clk);
    evt_pulse = '0; clr_wr = 1'b1; clr_mask = '1; clr_imprecise = 1'b1;
    @(negedge clk);
    quiet();
  endtask

  // present pulses for one edge, return at the next falling edge
  task automatic fire(input logic [N-1:0] p);
    evt_pulse = p;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; quiet(); evt_en = '0; own_hw = '0;
    int_mode = 1'b0; ext_mode = 1'b0; dbg_en = 1'b0;
    repeat (3) @(negedge clk);
    // R9: outputs at reset
    chk("R9 status at reset", int'(status), 0);
    chk("R9 imprecise at reset", int'(imprecise), 0);
    chk("R9 irq at reset", int'(irq), 0);
    chk("R9 halt at reset", int'(halt_req), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Sweep: modes x enable x ownership x event index (R1 R2 R4 R6 R7 R8)
    for (int m = 0; m < 8; m++) begin
      for (int o = 0; o < (1 << N); o++) begin
        for (int e = 0; e < 2; e++) begin
          for (int i = 0; i < N; i++) begin
            logic im, em, de, rec, sw;
            im = m[0]; em = m[1]; de = m[2];
            int_mode = im; ext_mode = em; dbg_en = de;
            own_hw = o[N-1:0];
            evt_en = e[0] ? (N'(1) << i) : ~(N'(1) << i);
            clear_all();
            fire(N'(1) << i);
            rec = e[0] & (im | em);
            sw  = ~(own_hw[i] & em);
            chk(rec ? "R1 status recorded" : "R2 status unchanged",
                int'(status), rec ? (1 << i) : 0);
            chk("R8 imprecise flag", int'(imprecise), int'(rec & ~de));
            chk(im ? "R4 irq level" : "R7 irq off without internal mode",
                int'(irq), int'(rec & im & de & sw));
            chk("R6 halt request", int'(halt_req), int'(rec & em & own_hw[i]));
          end
        end
      end
    end

    // R5: deferred interrupt appears when the enable rises
    int_mode = 1'b1; ext_mode = 1'b0; dbg_en = 1'b0; own_hw = '0; evt_en = '1;
    clear_all();
    fire(4'b0100);
    chk("R5 no irq while enable low", int'(irq), 0);
    chk("R8 deferred flag set", int'(imprecise), 1);
    repeat (3) @(negedge clk);
    dbg_en = 1'b1;
    #1;
    chk("R5 irq once enable rises", int'(irq), 1);
    // R8: flag stays when only status is cleared
    @(negedge clk);
    clr_wr = 1'b1; clr_mask = 4'b0100;
    @(negedge clk);
    quiet();
    chk("R3 cleared bit", int'(status), 0);
    chk("R4 irq drops with status", int'(irq), 0);
    chk("R8 flag survives status clear", int'(imprecise), 1);
    clr_imprecise = 1'b1;
    @(negedge clk);
    quiet();
    chk("R8 flag cleared", int'(imprecise), 0);

    // R3: stickiness, selective clear and set-over-clear
    clear_all();
    fire(4'b1001);
    repeat (5) @(negedge clk);
    chk("R3 sticky after idle", int'(status), 9);
    clr_wr = 1'b1; clr_mask = 4'b0110;
    @(negedge clk);
    quiet();
    chk("R3 clear of other bits ignored", int'(status), 9);
    clr_wr = 1'b1; clr_mask = 4'b0001;
    @(negedge clk);
    quiet();
    chk("R3 single bit cleared", int'(status), 8);
    clr_wr = 1'b1; clr_mask = 4'b1010; evt_pulse = 4'b0010;
    @(negedge clk);
    quiet();
    chk("R3 set wins over clear", int'(status), 2);
    // R2: modes off, pulses do not add bits
    int_mode = 1'b0; ext_mode = 1'b0;
    fire(4'b1101);
    chk("R2 modes off keep status", int'(status), 2);

    // R6: external mode, hardware bit pending only
    int_mode = 1'b1; ext_mode = 1'b1; dbg_en = 1'b1; own_hw = 4'b0010;
    #1;
    chk("R6 hw bit gives halt", int'(halt_req), 1);
    chk("R6 hw bit no irq", int'(irq), 0);
    ext_mode = 1'b0;
    #1;
    chk("R4 same bit software-owned without ext mode", int'(irq), 1);
    chk("R6 no halt without ext mode", int'(halt_req), 0);

    // R9: reset mid-run clears state
    rst_n = 1'b0;
    #1;
    chk("R9 status after reset", int'(status), 0);
    chk("R9 irq after reset", int'(irq), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule